// File: doc/BRIEF.md
# Programmable Quadrature Encoder Emulator

This block turns a stream of 14-bit absolute angle samples into the three signals of an incremental encoder: two quadrature phases A and B and a once-per-turn index I. The number of steps per revolution is chosen by a 3-bit resolution code and a decimal/binary mode bit. A 0.5 ms-class sensor front end can feed it sparse samples. When the angle jumps by many steps between two samples, the block does not skip edges. It walks its output position toward the new target one step at a time, along the shorter way around the circle, with no more than one step per `STEP_GAP` clock cycles.

A hysteresis filter with a programmable width sits in front of the stepper. It blocks small reversals of direction, so that a noisy angle near a step boundary does not make the output chatter. A direction-inversion bit swaps the sense of the A/B phase order. Until the first valid sample has been taken, all three outputs stay high. While the fault input is asserted, all three outputs are also forced high: samples are dropped and the position is held. Stepping resumes when the fault clears.

Top module: `qenc_emu`

## Requirements
- R1: From reset until the tracker has locked, out_a, out_b and out_i are all 1. The first sample accepted with smp_vld=1 is captured at clock edge k. The tracker locks directly onto its target at edge k+1, with no stepping, and the outputs show that position after edge k+2.
- R2: With bin_mode=0, res_sel codes 0 through 7 select 4000, 2000, 1600, 1200, 800, 400, 200 and 100 steps per revolution.
- R3: With bin_mode=1, res_sel codes 0, 1 and 2 select 4096, 2048 and 1024 steps. Codes 3 to 7 also select 1024.
- R4: The target step index is floor(angle × steps / 16384), where angle is the filtered angle.
- R5: The phase p is the position modulo 4 (when dir_inv=0). The outputs are (A,B) = (0,0), (1,0), (1,1), (0,1) for p = 0, 1, 2, 3. As a result, A leads B while the position increases.
- R6: With dir_inv=1, the phase is (−position) modulo 4, so B leads A while the position increases.
- R7: out_i is 1 exactly when the position is 0.
- R8: The position moves by at most one step per clock. Two steps are at least STEP_GAP cycles apart. Every step between the old position and the target produces exactly one A/B transition, so no step is lost.
- R9: The tracker steps toward the target along the shorter arc. When both arcs are equal, it steps forward (increasing position).
- R10: The filter always accepts a sample that continues the last direction of motion. It accepts a sample that reverses that direction only if the angle change magnitude exceeds (3 − hys_sel) × 8 angle LSBs. When hys_sel=3, any reversal is accepted.
- R11: When fault is high at an edge, all three outputs are 1 after that edge. Samples that arrive while fault is high are ignored, and the position is held. After fault clears, the outputs return to the held position.
- R12: A change of the selected step count relocks the tracker directly to the target for the new resolution, with no stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Angle sample strobe |
| angle | input | 14 | Absolute angle sample, 16384 counts per turn |
| res_sel | input | 3 | Resolution code |
| bin_mode | input | 1 | 1 = binary step counts, 0 = decimal |
| dir_inv | input | 1 | Inverts the A/B phase sense |
| hys_sel | input | 2 | Hysteresis code (3 = none) |
| fault | input | 1 | Error flag; forces the safe state |
| out_a | output | 1 | Quadrature phase A |
| out_b | output | 1 | Quadrature phase B |
| out_i | output | 1 | Index pulse |

## Verification
A corrupted position register shows up at the ports two clocks later. It appears as a wrong A/B phase, an index pulse at the wrong place, or a jump of two Gray states in one step. A fault in the gap counter or the arc decision changes how many A/B transitions occur between two settled positions, and how far apart they are. The bench counts those transitions and measures the spacing between them across a long jump and a wrap through zero. A hysteresis filter that keeps a wrong direction or threshold shows as a stable position that should have moved, or the reverse, within a few clocks of the sample.

// File: rtl/qe_pkg.sv
package qe_pkg;
  localparam int POS_W = 13;

  function automatic logic [POS_W-1:0] steps_for(input logic bin, input logic [2:0] code);
    logic [POS_W-1:0] s;
    if (bin) begin
      case (code)
        3'd0:    s = 13'd4096;
        3'd1:    s = 13'd2048;
        default: s = 13'd1024;
      endcase
    end else begin
      case (code)
        3'd0:    s = 13'd4000;
        3'd1:    s = 13'd2000;
        3'd2:    s = 13'd1600;
        3'd3:    s = 13'd1200;
        3'd4:    s = 13'd800;
        3'd5:    s = 13'd400;
        3'd6:    s = 13'd200;
        default: s = 13'd100;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/qe_angle_filter.sv
module qe_angle_filter #(
  parameter int ANG_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [ANG_W-1:0] angle,
  input  logic [1:0]       hys_sel,
  input  logic             fault,
  output logic [ANG_W-1:0] hang,
  output logic             primed
);
  localparam int HSH = ANG_W - 11;

  logic [ANG_W-1:0] hang_q, hang_n, d, mag, thr;
  logic             primed_q, primed_n, known_q, known_n, back_q, back_n;
  logic             neg, take;

  always_comb begin
    d        = angle - hang_q;
    neg      = d[ANG_W-1];
    mag      = neg ? (~d + 1'b1) : d;
    thr      = {{(ANG_W-2){1'b0}}, 2'd3 - hys_sel} << HSH;
    take     = smp_vld && !fault;
    hang_n   = hang_q;
    primed_n = primed_q;
    known_n  = known_q;
    back_n   = back_q;
    if (take) begin
      if (!primed_q) begin
        hang_n   = angle;
        primed_n = 1'b1;
        known_n  = 1'b0;
      end else if (d != '0) begin
        if (!known_q || (neg == back_q) || (mag > thr)) begin
          hang_n  = angle;
          known_n = 1'b1;
          back_n  = neg;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hang_q   <= '0;
      primed_q <= 1'b0;
      known_q  <= 1'b0;
      back_q   <= 1'b0;
    end else begin
      hang_q   <= hang_n;
      primed_q <= primed_n;
      known_q  <= known_n;
      back_q   <= back_n;
    end
  end

  assign hang   = hang_q;
  assign primed = primed_q;

  a_r10_hang_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld) |=> $stable(hang_q));
  a_r11_fault_drops_sample: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ($stable(hang_q) && $stable(primed_q)));
endmodule

// File: rtl/qe_step_tracker.sv
module qe_step_tracker #(
  parameter int ANG_W    = 14,
  parameter int POS_W    = 13,
  parameter int STEP_GAP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ANG_W-1:0] hang,
  input  logic             primed,
  input  logic [POS_W-1:0] steps,
  input  logic             hold,
  output logic [POS_W-1:0] pos,
  output logic             locked
);
  localparam int GW   = $clog2(STEP_GAP + 1);
  localparam int PR_W = ANG_W + POS_W;
  localparam logic [GW-1:0] GAP_RLD = GW'(STEP_GAP - 1);

  logic [PR_W-1:0]  prod;
  logic [POS_W-1:0] target, pos_q, pos_n, steps_q, pos_inc, pos_dec;
  logic [POS_W:0]   fwd;
  logic [GW-1:0]    gap_q, gap_n;
  logic             locked_q, locked_n, go_fwd, relock, step_en;

  always_comb begin
    prod    = {{POS_W{1'b0}}, hang} * {{ANG_W{1'b0}}, steps};
    target  = prod[PR_W-1:ANG_W];
    if (target >= pos_q) fwd = {1'b0, target} - {1'b0, pos_q};
    else                 fwd = {1'b0, target} + {1'b0, steps_q} - {1'b0, pos_q};
    go_fwd  = {fwd, 1'b0} <= {2'b00, steps_q};
    pos_inc = (pos_q == steps_q - 1'b1) ? '0 : pos_q + 1'b1;
    pos_dec = (pos_q == '0) ? steps_q - 1'b1 : pos_q - 1'b1;
    relock  = (steps != steps_q);
    step_en = locked_q && !relock && !hold && (gap_q == '0) && (fwd != '0);

    pos_n    = pos_q;
    locked_n = locked_q;
    gap_n    = (gap_q != '0) ? gap_q - 1'b1 : gap_q;
    if (relock) begin
      locked_n = 1'b0;
    end else if (!locked_q && primed) begin
      pos_n    = target;
      locked_n = 1'b1;
    end else if (step_en) begin
      pos_n = go_fwd ? pos_inc : pos_dec;
      gap_n = GAP_RLD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
      gap_q    <= '0;
      steps_q  <= '0;
    end else begin
      pos_q    <= pos_n;
      locked_q <= locked_n;
      gap_q    <= gap_n;
      steps_q  <= steps;
    end
  end

  assign pos    = pos_q;
  assign locked = locked_q;

  a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && $past(locked_q)) |->
      ((pos_q == $past(pos_q)) ||
       (pos_q == (($past(pos_q) == steps_q - 1'b1) ? '0 : $past(pos_q) + 1'b1)) ||
       (pos_q == (($past(pos_q) == '0) ? steps_q - 1'b1 : $past(pos_q) - 1'b1))));
  a_r8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && gap_q != '0) |=> $stable(pos_q));
  a_r12_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> (pos_q < steps_q));
  a_r11_hold_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && locked_q) |=> $stable(pos_q));
endmodule

// File: rtl/qe_phase_out.sv
module qe_phase_out #(
  parameter int POS_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos,
  input  logic             locked,
  input  logic             fault,
  input  logic             inv,
  output logic             out_a,
  output logic             out_b,
  output logic             out_i
);
  logic [1:0] ph;
  logic [2:0] abi_q, abi_n;
  logic       live, live_q;

  always_comb begin
    ph    = inv ? (2'd0 - pos[1:0]) : pos[1:0];
    live  = locked && !fault;
    abi_n = live ? {(ph == 2'd1) || (ph == 2'd2), ph[1], pos == '0} : 3'b111;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abi_q  <= 3'b111;
      live_q <= 1'b0;
    end else begin
      abi_q  <= abi_n;
      live_q <= live;
    end
  end

  assign out_a = abi_q[2];
  assign out_b = abi_q[1];
  assign out_i = abi_q[0];

  a_r11_safe_state: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (abi_q == 3'b111));
  a_r1_startup_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked) |=> (abi_q == 3'b111));
  a_r5_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(live_q) && ($past(inv) == $past(inv, 2))) |->
      ($countones(abi_q[2:1] ^ $past(abi_q[2:1])) <= 1));
endmodule

// File: rtl/qenc_emu.sv
module qenc_emu #(
  parameter int ANG_W    = 14,
  parameter int STEP_GAP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [ANG_W-1:0] angle,
  input  logic [2:0]       res_sel,
  input  logic             bin_mode,
  input  logic             dir_inv,
  input  logic [1:0]       hys_sel,
  input  logic             fault,
  output logic             out_a,
  output logic             out_b,
  output logic             out_i
);
  localparam int POS_W = qe_pkg::POS_W;

  logic [ANG_W-1:0] hang;
  logic [POS_W-1:0] steps, pos;
  logic             primed, locked;

  assign steps = qe_pkg::steps_for(bin_mode, res_sel);

  qe_angle_filter #(.ANG_W(ANG_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .angle(angle),
    .hys_sel(hys_sel), .fault(fault), .hang(hang), .primed(primed));

  qe_step_tracker #(.ANG_W(ANG_W), .POS_W(POS_W), .STEP_GAP(STEP_GAP)) u_trk (
    .clk(clk), .rst_n(rst_n), .hang(hang), .primed(primed), .steps(steps),
    .hold(fault), .pos(pos), .locked(locked));

  qe_phase_out #(.POS_W(POS_W)) u_out (
    .clk(clk), .rst_n(rst_n), .pos(pos), .locked(locked), .fault(fault),
    .inv(dir_inv), .out_a(out_a), .out_b(out_b), .out_i(out_i));
endmodule

// File: tb/qenc_emu_tb_top.sv
module qenc_emu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 2;
  localparam int SETTLE     = 4300;
  localparam int NV         = 12;

  // vector: {angle[13:0], bin, res[2:0], inv}
  localparam logic [18:0] VEC [NV] = '{
    {14'd0,     1'b1, 3'd0, 1'b0},
    {14'd4,     1'b1, 3'd0, 1'b0},
    {14'd8,     1'b1, 3'd0, 1'b0},
    {14'd12,    1'b1, 3'd0, 1'b0},
    {14'd4,     1'b1, 3'd0, 1'b1},
    {14'd16383, 1'b1, 3'd1, 1'b0},
    {14'd5000,  1'b1, 3'd5, 1'b0},
    {14'd5000,  1'b0, 3'd0, 1'b0},
    {14'd8191,  1'b0, 3'd7, 1'b0},
    {14'd100,   1'b0, 3'd3, 1'b0},
    {14'd82,    1'b0, 3'd6, 1'b0},
    {14'd81,    1'b0, 3'd6, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0, bin_mode = 1'b1, dir_inv = 1'b0, fault = 1'b0;
  logic [13:0] angle = '0;
  logic [2:0]  res_sel = '0;
  logic [1:0]  hys_sel = 2'd3;
  logic out_a, out_b, out_i;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int cyc = 0, mon_en = 0, mon_edges = 0, mon_min = 1000000, mon_last = -1, mon_irise = 0;
  logic [1:0] mon_prev;
  logic       mon_iprev;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  qenc_emu #(.ANG_W(14), .STEP_GAP(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .angle(angle), .res_sel(res_sel),
    .bin_mode(bin_mode), .dir_inv(dir_inv), .hys_sel(hys_sel), .fault(fault),
    .out_a(out_a), .out_b(out_b), .out_i(out_i));

  always @(negedge clk) begin
    if (mon_en != 0) begin
      if ({out_a, out_b} != mon_prev) begin
        mon_edges++;
        if (mon_last >= 0 && (cyc - mon_last) < mon_min) mon_min = cyc - mon_last;
        mon_last = cyc;
      end
      if (out_i && !mon_iprev) mon_irise++;
    end
    mon_prev  = {out_a, out_b};
    mon_iprev = out_i;
  end

  function automatic int steps_m(input logic b, input logic [2:0] r);
    if (b) return (r == 3'd0) ? 4096 : (r == 3'd1) ? 2048 : 1024;
    case (r)
      3'd0: return 4000; 3'd1: return 2000; 3'd2: return 1600; 3'd3: return 1200;
      3'd4: return 800;  3'd5: return 400;  3'd6: return 200;  default: return 100;
    endcase
  endfunction

  function automatic logic [2:0] abi_m(input int p, input logic inv);
    int ph;
    ph = inv ? ((4 - (p % 4)) % 4) : (p % 4);
    return {(ph == 1) || (ph == 2), ph >= 2, p == 0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [13:0] a);
    angle = a; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    do_reset();
    chk("R1 reset outputs high", {out_a, out_b, out_i}, 3'b111);
    tick(5);
    chk("R1 high before first sample", {out_a, out_b, out_i}, 3'b111);
    bin_mode = 1'b1; res_sel = 3'd0;
    send(14'd20);
    tick(1);
    chk("R1 not yet locked at k+1", {out_a, out_b, out_i}, 3'b111);
    tick(1);
    chk("R1 direct lock at k+2", {out_a, out_b, out_i}, abi_m(5, 1'b0));

    // vector table: R2 R3 R4 R5 R6 R7 R12
    for (int v = 0; v < NV; v++) begin
      bin_mode = VEC[v][4]; res_sel = VEC[v][3:1]; dir_inv = VEC[v][0];
      tick(1);
      send(VEC[v][18:5]);
      tick(SETTLE);
      chk($sformatf("R2/R3/R4/R5/R6/R7/R12 vector %0d", v), {out_a, out_b, out_i},
          abi_m((int'(VEC[v][18:5]) * steps_m(VEC[v][4], VEC[v][3:1])) / 16384, VEC[v][0]));
    end

    // R8: jump of 10 steps, all edges kept, spacing >= GAP
    do_reset();
    bin_mode = 1'b1; res_sel = 3'd0; dir_inv = 1'b0; hys_sel = 2'd3;
    send(14'd0); tick(4);
    mon_edges = 0; mon_min = 1000000; mon_last = -1; mon_irise = 0; mon_en = 1;
    send(14'd40); tick(60);
    mon_en = 0;
    chk("R8 ten steps give ten AB edges", mon_edges, 10);
    chk("R8 edge spacing at least gap", (mon_min >= GAP), 1);
    chk("R8 final phase", {out_a, out_b, out_i}, abi_m(10, 1'b0));

    // R9: shorter arc backwards through zero
    send(14'd4); tick(60);
    mon_edges = 0; mon_irise = 0; mon_en = 1;
    send(14'd16380); tick(30);
    mon_en = 0;
    chk("R9 backward arc edge count", mon_edges, 2);
    chk("R7 index pulses once through zero", mon_irise, 1);
    chk("R9 final backward position", {out_a, out_b, out_i}, abi_m(4095, 1'b0));

    // R9: tie goes forward (100 steps, 0 -> 50)
    bin_mode = 1'b0; res_sel = 3'd7;
    tick(2); send(14'd0); tick(6);
    chk("R12 relock at 100 steps", {out_a, out_b, out_i}, abi_m(0, 1'b0));
    send(14'd8192); tick(2);
    chk("R9 tie steps forward first", {out_a, out_b, out_i}, abi_m(1, 1'b0));
    tick(200);
    chk("R9 tie reaches half turn", {out_a, out_b, out_i}, abi_m(50, 1'b0));

    // R10: hysteresis 3 coarse LSB = 24 counts
    do_reset();
    bin_mode = 1'b1; res_sel = 3'd0; hys_sel = 2'd0;
    send(14'd0); tick(4);
    send(14'd1000); tick(700);
    chk("R10 forward move accepted", {out_a, out_b, out_i}, abi_m(250, 1'b0));
    send(14'd976); tick(40);
    chk("R10 reversal of 24 ignored", {out_a, out_b, out_i}, abi_m(250, 1'b0));
    send(14'd975); tick(40);
    chk("R10 reversal of 25 accepted", {out_a, out_b, out_i}, abi_m(243, 1'b0));

    // R11: fault freeze, ignored samples, resume
    fault = 1'b1; tick(1);
    chk("R11 safe state after fault edge", {out_a, out_b, out_i}, 3'b111);
    send(14'd2000); tick(20);
    chk("R11 still safe during fault", {out_a, out_b, out_i}, 3'b111);
    fault = 1'b0; tick(40);
    chk("R11 resumes held position", {out_a, out_b, out_i}, abi_m(243, 1'b0));

    report();
  end
endmodule